// File: doc/BRIEF.md
# Banked Memory-Attribute Remap Register Controller

This block owns a 32-bit control register that remaps memory attributes. It keeps two copies of the register, one for the secure world and one for the non-secure world. Each cycle it can take one coprocessor-style request. A request carries a coprocessor number, two opcode fields, two register-number fields, a direction and write data. The block first checks that the encoding names this register. It then resolves the request against the current privilege level (0 to 3), the hypervisor trap enables, the two secure write-disable inputs and the platform configuration. The configuration says whether level 2 is enabled, whether level 2 runs in 32-bit state, and whether level 3 exists and runs in 32-bit state.

The result is registered and appears one cycle after the request. It consists of an outcome code, a trap syndrome class, a flag that tells whether a trap goes to a 32-bit hypervisor, and the read data. The copies are banked only when level 3 exists and runs in 32-bit state. In every other configuration the non-secure storage acts as the single, unbanked register.

Top module: `sysreg_bank_ctrl`

## Requirements
- R1: A request produces a response only when coprocessor=15, opc1=0, CRn=10, CRm=2 and opc2=1. For any other encoding, or with no valid request, result_o is 2'b00 in the next cycle and no copy changes.
- R2: A decoded request at privilege level 0 gives result_o=2'b10 (undefined), whatever the other inputs are.
- R3: At level 1 with level 2 enabled, a set coprocessor-10 hypervisor trap bit has top priority for both reads and writes. It gives result_o=2'b11 (trap) and syndrome_o=6'h03, and trap_hyp_o equals the level-2 32-bit configuration input.
- R4: At level 1 with level 2 enabled and no coprocessor-10 trap, a read with the virtual-memory read trap set gives a trap with class 6'h03. The virtual-memory write trap and the secure disable inputs have no effect on reads.
- R5: At level 1, a write that reaches the banked secure copy (level 3 present and 32-bit, ns_i=0) gives undefined when either secure disable input is high. This check sits above the virtual-memory write trap, which then traps with class 6'h03 when level 2 is enabled.
- R6: At level 1 with no trap or undefined outcome, ns_i=0 selects the secure copy and ns_i=1 selects the non-secure copy when level 3 is present and 32-bit. Otherwise the single (non-secure storage) copy is used.
- R7: At level 2, a decoded access always succeeds and uses the non-secure storage, whether or not the register is banked.
- R8: At level 3, a write with ns_i=0 and either secure disable input high gives undefined. Reads at level 3 always succeed.
- R9: At level 3, ns_i=0 selects the secure copy and ns_i=1 selects the non-secure copy.
- R10: After reset both copies read as zero.
- R11: Outcome codes are 00 none, 01 success, 10 undefined, 11 trap. rdata_o is zero unless a read succeeded, and syndrome_o is zero unless the outcome is trap. A write updates only the selected copy and only on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| cp_num_i | input | 4 | Coprocessor number |
| op1_i | input | 3 | First opcode field |
| crn_i | input | 4 | Primary register number |
| crm_i | input | 4 | Secondary register number |
| op2_i | input | 3 | Second opcode field |
| wdata_i | input | 32 | Write data |
| priv_lvl_i | input | 2 | Current privilege level |
| ns_i | input | 1 | Non-secure state bit |
| el2_en_i | input | 1 | Level 2 enabled |
| el2_a32_i | input | 1 | Level 2 uses 32-bit state |
| el3_present_i | input | 1 | Level 3 exists |
| el3_a32_i | input | 1 | Level 3 uses 32-bit state |
| hyp_cp10_trap_i | input | 1 | Hypervisor coprocessor-10 trap bit |
| trap_vm_rd_i | input | 1 | Trap virtual-memory register reads |
| trap_vm_wr_i | input | 1 | Trap virtual-memory register writes |
| sec_wr_dis_i | input | 1 | Secure write disable, first input |
| sec_wr_dis2_i | input | 1 | Secure write disable, second input |
| result_o | output | 2 | Outcome code |
| syndrome_o | output | 6 | Trap syndrome class |
| trap_hyp_o | output | 1 | Trap is taken to a 32-bit level 2 |
| rdata_o | output | 32 | Read data |

## Verification
The assertions assume that every input is stable and known at the clock edge, and that priv_lvl_i is 3 only when level 3 is present. The block itself gives level 3 a defined banked behaviour in every case. The bench holds all inputs constant between falling edges. It sweeps the full cross product of privilege level, direction, NS bit, trap enables, disable inputs and configuration, so every priority branch of the chain is reached. It also injects undecoded encodings and idle cycles, and confirms that they leave both copies unchanged.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SYND_W = 6;
  localparam int unsigned N_BANK = 2;

  localparam logic [SYND_W-1:0] SYND_CP_ACC = 6'h03;

  typedef enum logic [1:0] {
    RES_NONE  = 2'b00,
    RES_OK    = 2'b01,
    RES_UNDEF = 2'b10,
    RES_TRAP  = 2'b11
  } res_e;

  typedef enum logic [0:0] {
    BANK_NS  = 1'b0,
    BANK_SEC = 1'b1
  } bank_e;

  typedef struct packed {
    logic       valid;
    logic       write;
    logic [1:0] priv;
    logic       ns;
  } acc_t;

  typedef struct packed {
    logic el2_en;
    logic el2_a32;
    logic banked;
    logic cp10_trap;
    logic vm_rd_trap;
    logic vm_wr_trap;
    logic sec_dis;
  } ctl_t;
endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode #(
  parameter logic [3:0] CP_NUM = 4'd15,
  parameter logic [2:0] OP1    = 3'd0,
  parameter logic [3:0] CRN    = 4'd10,
  parameter logic [3:0] CRM    = 4'd2,
  parameter logic [2:0] OP2    = 3'd1
) (
  input  logic       valid_i,
  input  logic [3:0] cp_num_i,
  input  logic [2:0] op1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  output logic       hit_o
);
  logic [4:0] fld_match;

  always_comb begin
    fld_match[0] = (cp_num_i == CP_NUM);
    fld_match[1] = (op1_i    == OP1);
    fld_match[2] = (crn_i    == CRN);
    fld_match[3] = (crm_i    == CRM);
    fld_match[4] = (op2_i    == OP2);
  end

  assign hit_o = valid_i & (&fld_match);
endmodule

// File: rtl/sysreg_access_arb.sv
module sysreg_access_arb
  import sysreg_pkg::*;
(
  input  acc_t  acc_i,
  input  ctl_t  ctl_i,
  output res_e  res_o,
  output bank_e bank_o,
  output logic  trap_hyp_o
);
  logic sec_side;

  assign sec_side = ~acc_i.ns;

  always_comb begin
    res_o      = RES_NONE;
    bank_o     = BANK_NS;
    trap_hyp_o = 1'b0;
    if (acc_i.valid) begin
      unique case (acc_i.priv)
        2'd0: res_o = RES_UNDEF;
        2'd1: begin
          if (ctl_i.el2_en && ctl_i.cp10_trap) begin
            res_o = RES_TRAP;
          end else if (!acc_i.write && ctl_i.el2_en && ctl_i.vm_rd_trap) begin
            res_o = RES_TRAP;
          end else if (acc_i.write && ctl_i.banked && sec_side && ctl_i.sec_dis) begin
            res_o = RES_UNDEF;
          end else if (acc_i.write && ctl_i.el2_en && ctl_i.vm_wr_trap) begin
            res_o = RES_TRAP;
          end else begin
            res_o  = RES_OK;
            bank_o = (ctl_i.banked && sec_side) ? BANK_SEC : BANK_NS;
          end
          trap_hyp_o = (res_o == RES_TRAP) & ctl_i.el2_a32;
        end
        2'd2: begin
          res_o  = RES_OK;
          bank_o = BANK_NS;
        end
        default: begin
          if (acc_i.write && sec_side && ctl_i.sec_dis) begin
            res_o = RES_UNDEF;
          end else begin
            res_o  = RES_OK;
            bank_o = sec_side ? BANK_SEC : BANK_NS;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sysreg_bank_store.sv
module sysreg_bank_store
  import sysreg_pkg::*;
#(
  parameter int unsigned W     = DATA_W,
  parameter int unsigned BANKS = N_BANK,
  localparam int unsigned SEL_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     rdata_o
);
  logic [W-1:0] bank_q [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit_we;
    assign hit_we = we_i && (sel_i == SEL_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bank_q[b] <= '0;
      else if (hit_we) bank_q[b] <= wdata_i;
    end
  end

  assign rdata_o = bank_q[sel_i];
endmodule

// File: rtl/sysreg_bank_ctrl.sv
module sysreg_bank_ctrl
  import sysreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [3:0]        cp_num_i,
  input  logic [2:0]        op1_i,
  input  logic [3:0]        crn_i,
  input  logic [3:0]        crm_i,
  input  logic [2:0]        op2_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        priv_lvl_i,
  input  logic              ns_i,
  input  logic              el2_en_i,
  input  logic              el2_a32_i,
  input  logic              el3_present_i,
  input  logic              el3_a32_i,
  input  logic              hyp_cp10_trap_i,
  input  logic              trap_vm_rd_i,
  input  logic              trap_vm_wr_i,
  input  logic              sec_wr_dis_i,
  input  logic              sec_wr_dis2_i,
  output logic [1:0]        result_o,
  output logic [SYND_W-1:0] syndrome_o,
  output logic              trap_hyp_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              hit;
  acc_t              acc;
  ctl_t              ctl;
  res_e              res;
  bank_e             bank;
  logic              trap_hyp;
  logic [DATA_W-1:0] store_rd;

  sysreg_decode u_dec (
    .valid_i (req_valid_i),
    .cp_num_i(cp_num_i),
    .op1_i   (op1_i),
    .crn_i   (crn_i),
    .crm_i   (crm_i),
    .op2_i   (op2_i),
    .hit_o   (hit)
  );

  always_comb begin
    acc.valid      = hit;
    acc.write      = req_write_i;
    acc.priv       = priv_lvl_i;
    acc.ns         = ns_i;
    ctl.el2_en     = el2_en_i;
    ctl.el2_a32    = el2_a32_i;
    ctl.banked     = el3_present_i & el3_a32_i;
    ctl.cp10_trap  = hyp_cp10_trap_i;
    ctl.vm_rd_trap = trap_vm_rd_i;
    ctl.vm_wr_trap = trap_vm_wr_i;
    ctl.sec_dis    = sec_wr_dis_i | sec_wr_dis2_i;
  end

  sysreg_access_arb u_arb (
    .acc_i     (acc),
    .ctl_i     (ctl),
    .res_o     (res),
    .bank_o    (bank),
    .trap_hyp_o(trap_hyp)
  );

  sysreg_bank_store #(.W(DATA_W), .BANKS(N_BANK)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   ((res == RES_OK) && req_write_i),
    .sel_i  (bank),
    .wdata_i(wdata_i),
    .rdata_o(store_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o   <= RES_NONE;
      syndrome_o <= '0;
      trap_hyp_o <= 1'b0;
      rdata_o    <= '0;
    end else begin
      result_o   <= res;
      syndrome_o <= (res == RES_TRAP) ? SYND_CP_ACC : '0;
      trap_hyp_o <= trap_hyp;
      rdata_o    <= ((res == RES_OK) && !req_write_i) ? store_rd : '0;
    end
  end

  // R1
  undecoded_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> result_o == RES_NONE);
  // R2
  lvl0_undef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && priv_lvl_i == 2'd0 |=> result_o == RES_UNDEF);
  // R3
  cp10_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && priv_lvl_i == 2'd1 && el2_en_i && hyp_cp10_trap_i
      |=> result_o == RES_TRAP && syndrome_o == SYND_CP_ACC);
  // R7
  lvl2_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && priv_lvl_i == 2'd2 |=> result_o == RES_OK);
  // R8
  lvl3_read_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && priv_lvl_i == 2'd3 && !req_write_i |=> result_o == RES_OK);
  // R11
  rdata_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o != RES_OK |-> rdata_o == '0);
  // R11
  synd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o != RES_TRAP |-> syndrome_o == '0);
  // R11
  no_write_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit && req_write_i) |=> $stable(u_store.bank_q[0]) && $stable(u_store.bank_q[1]));
endmodule

// File: tb/sysreg_bank_ctrl_tb.sv
module sysreg_bank_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [3:0]  cp_num_i = '0, crn_i = '0, crm_i = '0;
  logic [2:0]  op1_i = '0, op2_i = '0;
  logic [31:0] wdata_i = '0;
  logic [1:0]  priv_lvl_i = '0;
  logic        ns_i = 0, el2_en_i = 0, el2_a32_i = 0, el3_present_i = 0, el3_a32_i = 0;
  logic        hyp_cp10_trap_i = 0, trap_vm_rd_i = 0, trap_vm_wr_i = 0;
  logic        sec_wr_dis_i = 0, sec_wr_dis2_i = 0;
  logic [1:0]  result_o;
  logic [5:0]  syndrome_o;
  logic        trap_hyp_o;
  logic [31:0] rdata_o;

  int total = 0, bad = 0;
  logic [31:0] m_sec = '0, m_ns = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk_i = ~clk_i;

  sysreg_bank_ctrl dut_i (.*);

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(string req, logic [1:0] er, logic [5:0] es, logic eh, logic [31:0] ed);
    total++;
    if (result_o !== er || syndrome_o !== es || trap_hyp_o !== eh || rdata_o !== ed) begin
      bad++;
      $display("FAIL %s: actual res=%b syn=%h hyp=%b data=%h expected res=%b syn=%h hyp=%b data=%h",
               req, result_o, syndrome_o, trap_hyp_o, rdata_o, er, es, eh, ed);
    end
  endtask

  // Drive one request at negedge, check response at next negedge.
  task automatic access(string req, bit v, bit dec, bit wr, int lvl, bit ns, bit e2, bit e2a,
                        bit e3p, bit e3a, bit cp10, bit trd, bit twr, bit d1, bit d2,
                        logic [31:0] wd);
    logic [1:0] er; logic [5:0] es; logic eh; logic [31:0] ed;
    bit banked, use_sec;
    req_valid_i = v; req_write_i = wr;
    cp_num_i = 4'd15; op1_i = 3'd0; crn_i = 4'd10; crm_i = 4'd2; op2_i = 3'd1;
    if (!dec) crm_i = 4'd3;
    priv_lvl_i = 2'(lvl); ns_i = ns; el2_en_i = e2; el2_a32_i = e2a;
    el3_present_i = e3p; el3_a32_i = e3a; hyp_cp10_trap_i = cp10;
    trap_vm_rd_i = trd; trap_vm_wr_i = twr; sec_wr_dis_i = d1; sec_wr_dis2_i = d2;
    wdata_i = wd;
    banked = e3p && e3a;
    use_sec = 0; er = 2'b00;
    if (v && dec) begin
      if (lvl == 0) er = 2'b10;
      else if (lvl == 1) begin
        if (e2 && cp10) er = 2'b11;
        else if (!wr && e2 && trd) er = 2'b11;
        else if (wr && banked && !ns && (d1 || d2)) er = 2'b10;
        else if (wr && e2 && twr) er = 2'b11;
        else begin er = 2'b01; use_sec = banked && !ns; end
      end else if (lvl == 2) er = 2'b01;
      else begin
        if (wr && !ns && (d1 || d2)) er = 2'b10;
        else begin er = 2'b01; use_sec = !ns; end
      end
    end
    es = (er == 2'b11) ? 6'h03 : 6'h00;
    eh = (er == 2'b11) && e2a;
    ed = (er == 2'b01 && !wr) ? (use_sec ? m_sec : m_ns) : 32'h0;
    @(negedge clk_i);
    check(req, er, es, eh, ed);
    if (er == 2'b01 && wr) begin
      if (use_sec) m_sec = wd; else m_ns = wd;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R10
    check("R10 reset outputs", 2'b00, 6'h0, 1'b0, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    access("R10 secure copy zero", 1,1,0,3,0,0,0,1,1,0,0,0,0,0, 32'h0);
    access("R10 ns copy zero",     1,1,0,3,1,0,0,1,1,0,0,0,0,0, 32'h0);
    // R9 isolation
    access("R9 write secure",   1,1,1,3,0,0,0,1,1,0,0,0,0,0, 32'hA5A5_0001);
    access("R9 write ns",       1,1,1,3,1,0,0,1,1,0,0,0,0,0, 32'h5A5A_0002);
    access("R9 read secure",    1,1,0,3,0,0,0,1,1,0,0,0,0,0, 32'h0);
    access("R9 read ns",        1,1,0,3,1,0,0,1,1,0,0,0,0,0, 32'h0);
    // R1
    access("R1 undecoded write", 1,0,1,3,0,0,0,1,1,0,0,0,0,0, 32'hDEAD_BEEF);
    access("R1 idle write",      0,1,1,3,0,0,0,1,1,0,0,0,0,0, 32'hDEAD_BEEF);
    access("R1 secure unchanged",1,1,0,3,0,0,0,1,1,0,0,0,0,0, 32'h0);
    // R8
    access("R8 blocked write",  1,1,1,3,0,0,0,1,1,0,0,0,0,1, 32'h0BAD_0BAD);
    access("R8 read with dis",  1,1,0,3,0,0,0,1,1,0,0,0,1,1, 32'h0);
    // R7
    access("R7 lvl2 write ns",  1,1,1,2,0,1,0,1,1,1,1,1,1,1, 32'h2222_2222);
    access("R7 lvl2 read",      1,1,0,2,0,1,0,1,1,0,0,0,0,0, 32'h0);
    access("R7 secure intact",  1,1,0,3,0,0,0,1,1,0,0,0,0,0, 32'h0);
    // R2 R3 R4 R5 R6 R8 R9 R11: full cross product
    for (int i = 0; i < 8192; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      access("R11 sweep", 1, 1, i[0], int'(i[2:1]), i[3], i[4], i[5], i[6], i[7],
             i[8], i[9], i[10], i[11], i[12], seed);
      if (i % 16 == 0) access("R1 sweep undecoded", 1, 0, 1, 3, 0, 0,0,1,1,0,0,0,0,0, ~seed);
    end
    access("R6 final secure", 1,1,0,3,0,0,0,1,1,0,0,0,0,0, 32'h0);
    access("R6 final ns",     1,1,0,3,1,0,0,1,1,0,0,0,0,0, 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule